// File: doc/BRIEF.md
# Interleaved Regulator Loop Controller

This block is the digital control core of a push-pull linear voltage regulator. Up to three comparator channels watch the regulated output. Their sample instants are spread evenly across one period of a shared ring oscillator. Each channel reports a two-bit code that says whether the sensed voltage is under, inside or over a narrow band around the reference. The controller visits the active channels one per clock in round-robin order, so the loop updates N times per oscillator period. It decodes the chosen code into a raise, hold or lower command, and applies that command to per-group push and pull gate drive codes. The push and pull codes always move in opposite directions.

A level setting picks one of six output voltages. From it the block derives two things: a one-hot selection of the matching feedback divider tap, and a cumulative mask of the output-device groups that are enabled. Only enabled groups respond to commands. A group that falls out of the mask is driven off immediately. While the enable input is low, every code is ignored and the drive state is held.

Top module: `ldo_loop_ctrl`

## Requirements
- R1: When the selected channel code is 2'b11 (bit 1 = first flop, bit 0 = second flop; output below target), each enabled group's push drive rises by 1 and its pull drive falls by 1 at the next clock edge.
- R2: A selected code of 2'b01 (in band) leaves every enabled group's push and pull drive unchanged.
- R3: A selected code of 2'b00 (output above target) lowers each enabled group's push drive by 1 and raises its pull drive by 1 at the next edge.
- R4: Each drive code is 6 bits wide and saturates: it never wraps past 63 or below 0.
- R5: Channel c's code sits at code_i[2c+1:2c]. With N active channels (n_ch_i = 1, 2 or 3; 0 is treated as 1), the channel used each enabled cycle steps 0, 1, …, N-1 and then wraps. ch_sel_o shows the channel used in the current cycle.
- R6: While en_i is low, codes have no effect, the drive codes hold, and no error is flagged. The first enabled cycle afterwards uses channel 0.
- R7: level_i = L (0..5) makes bit L of tap_sel_o the only set bit. Values above 5 act as 5.
- R8: grp_en_o has bits 0..L set and the rest clear. A disabled group reads 0 on both drive outputs in the same cycle and restarts from 0 when it is enabled again.
- R9: The unused code 2'b10 acts as a hold and sets err_o from the next edge until reset.
- R10: When N changes, the next channel used is the pointer modulo the new N, and stepping continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Detector enable; low freezes the loop |
| n_ch_i | input | 2 | Number of active channels (1..3) |
| code_i | input | 6 | Two-bit comparator code per channel |
| level_i | input | 3 | Output level setting (0..5) |
| tap_sel_o | output | 6 | One-hot divider tap selection |
| grp_en_o | output | 6 | Cumulative output-group enable mask |
| push_drv_o | output | 36 | Push drive code per group, 6 bits each, group g at [6g+5:6g] |
| pull_drv_o | output | 36 | Pull drive code per group, same packing |
| ch_sel_o | output | 2 | Channel used in the current cycle |
| err_o | output | 1 | Sticky invalid-code flag |

## Verification
The hardest case to reach is a channel-count change while the pointer sits above the new count. It only occurs after a run of enabled cycles under three channels has left the pointer on channel 2. The stimulus sets up that state, switches to two channels in the next cycle, and gives each channel a distinct code. The channel actually used then shows up directly in the direction the drive codes move. Saturation at both ends is reached by holding one code for more than 63 cycles. A group that is dropped and later re-enabled is checked to restart from 0.

// File: rtl/ldo_loop_pkg.sv
package ldo_loop_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_RAISE = 2'd1,
    CMD_LOWER = 2'd2
  } cmd_e;

  localparam logic [1:0] CODE_BELOW = 2'b11;
  localparam logic [1:0] CODE_BAND  = 2'b01;
  localparam logic [1:0] CODE_ABOVE = 2'b00;
  localparam logic [1:0] CODE_BAD   = 2'b10;
endpackage

// File: rtl/ldo_code_decode.sv
module ldo_code_decode
  import ldo_loop_pkg::*;
(
  input  logic       en_i,
  input  logic [1:0] code_i,
  output cmd_e       cmd_o,
  output logic       bad_o
);
  always_comb begin
    cmd_o = CMD_HOLD;
    bad_o = 1'b0;
    if (en_i) begin
      unique case (code_i)
        CODE_BELOW: cmd_o = CMD_RAISE;
        CODE_ABOVE: cmd_o = CMD_LOWER;
        CODE_BAND:  cmd_o = CMD_HOLD;
        default:    bad_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({en_i, code_i})) begin
      p_idle_hold_r6: assert (en_i || (cmd_o == CMD_HOLD && !bad_o));
    end
  end
endmodule

// File: rtl/ldo_ch_arbiter.sv
module ldo_ch_arbiter #(
  parameter int MAX_CH = 3,
  localparam int CH_W  = $clog2(MAX_CH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [CH_W-1:0] n_ch_i,
  output logic [CH_W-1:0] sel_o
);
  localparam logic [CH_W-1:0] MAX_N = CH_W'(MAX_CH);

  logic [CH_W-1:0] ptr_q, nxt, n_eff;

  always_comb begin
    if (n_ch_i == '0)        n_eff = CH_W'(1);
    else if (n_ch_i > MAX_N) n_eff = MAX_N;
    else                     n_eff = n_ch_i;
  end

  // pointer is reduced modulo the live count so a shrinking N wraps
  assign sel_o = ptr_q % n_eff;
  assign nxt   = (CH_W'(sel_o + 1'b1) == n_eff) ? '0 : CH_W'(sel_o + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (!en_i) ptr_q <= '0;
    else            ptr_q <= nxt;
  end

  p_sel_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o < n_eff);
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> sel_o == '0);
  p_rr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ($stable(n_eff) ->
      sel_o == ((CH_W'($past(sel_o) + 1'b1) == $past(n_eff)) ? '0
                : CH_W'($past(sel_o) + 1'b1))));
endmodule

// File: rtl/ldo_lvl_decode.sv
module ldo_lvl_decode #(
  parameter int N_GRP = 6,
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] level_i,
  output logic [N_GRP-1:0] tap_o,
  output logic [N_GRP-1:0] grp_o
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(N_GRP - 1);

  logic [LVL_W-1:0] lvl;
  assign lvl = (level_i > TOP) ? TOP : level_i;

  for (genvar g = 0; g < N_GRP; g++) begin : g_bit
    assign tap_o[g] = (lvl == LVL_W'(g));
    assign grp_o[g] = (LVL_W'(g) <= lvl);
  end

  always_comb begin
    if (!$isunknown(level_i)) begin
      p_tap_onehot_r7: assert ($onehot(tap_o));
      p_grp_cumulative_r8: assert (grp_o == N_GRP'((tap_o << 1) - 1'b1));
    end
  end
endmodule

// File: rtl/ldo_drive_cell.sv
module ldo_drive_cell
  import ldo_loop_pkg::*;
#(
  parameter int DRV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grp_en_i,
  input  cmd_e             cmd_i,
  output logic [DRV_W-1:0] push_o,
  output logic [DRV_W-1:0] pull_o
);
  localparam logic [DRV_W-1:0] FULL = '1;

  logic [DRV_W-1:0] push_q, pull_q, push_d, pull_d;

  always_comb begin
    push_d = push_q;
    pull_d = pull_q;
    if (!grp_en_i) begin
      push_d = '0;
      pull_d = '0;
    end else if (cmd_i == CMD_RAISE) begin
      if (push_q != FULL) push_d = push_q + 1'b1;
      if (pull_q != '0)   pull_d = pull_q - 1'b1;
    end else if (cmd_i == CMD_LOWER) begin
      if (push_q != '0)   push_d = push_q - 1'b1;
      if (pull_q != FULL) pull_d = pull_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= '0;
      pull_q <= '0;
    end else begin
      push_q <= push_d;
      pull_q <= pull_d;
    end
  end

  // disabled group reads off in the same cycle
  assign push_o = grp_en_i ? push_q : '0;
  assign pull_o = grp_en_i ? pull_q : '0;

  p_no_wrap_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_en_i && cmd_i == CMD_RAISE && push_q == FULL) |=> push_q == FULL);
  p_no_wrap_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_en_i && cmd_i == CMD_RAISE && pull_q == '0) |=> pull_q == '0);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_en_i && cmd_i == CMD_HOLD) |=> ($stable(push_q) && $stable(pull_q)));
  p_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_en_i |=> (push_q == '0 && pull_q == '0));
endmodule

// File: rtl/ldo_loop_ctrl.sv
module ldo_loop_ctrl
  import ldo_loop_pkg::*;
#(
  parameter int MAX_CH = 3,
  parameter int N_GRP  = 6,
  parameter int DRV_W  = 6,
  parameter int LVL_W  = 3,
  localparam int CH_W  = $clog2(MAX_CH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [CH_W-1:0]        n_ch_i,
  input  logic [2*MAX_CH-1:0]    code_i,
  input  logic [LVL_W-1:0]       level_i,
  output logic [N_GRP-1:0]       tap_sel_o,
  output logic [N_GRP-1:0]       grp_en_o,
  output logic [N_GRP*DRV_W-1:0] push_drv_o,
  output logic [N_GRP*DRV_W-1:0] pull_drv_o,
  output logic [CH_W-1:0]        ch_sel_o,
  output logic                   err_o
);
  logic [CH_W-1:0] sel;
  logic [1:0]      code_sel;
  cmd_e            cmd;
  logic            bad;
  logic            err_q;

  ldo_ch_arbiter #(.MAX_CH(MAX_CH)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .n_ch_i(n_ch_i),
    .sel_o (sel)
  );

  assign code_sel = code_i[2*sel +: 2];
  assign ch_sel_o = sel;

  ldo_code_decode u_dec (
    .en_i  (en_i),
    .code_i(code_sel),
    .cmd_o (cmd),
    .bad_o (bad)
  );

  ldo_lvl_decode #(.N_GRP(N_GRP), .LVL_W(LVL_W)) u_lvl (
    .level_i(level_i),
    .tap_o  (tap_sel_o),
    .grp_o  (grp_en_o)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    ldo_drive_cell #(.DRV_W(DRV_W)) u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .grp_en_i(grp_en_o[g]),
      .cmd_i   (cmd),
      .push_o  (push_drv_o[g*DRV_W +: DRV_W]),
      .pull_o  (pull_drv_o[g*DRV_W +: DRV_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end
  assign err_o = err_q;

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_sel == CODE_BAD) |=> err_o);
  p_idle_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $stable(level_i)) |=> ($stable(push_drv_o) && $stable(pull_drv_o)));
endmodule

// File: tb/tb_ldo_loop_ctrl.sv
`timescale 1ns/1ps
module tb_ldo_loop_ctrl;
  localparam int NG = 6;
  localparam int DW = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  n_ch_i = 2'd1;
  logic [5:0]  code_i = 6'b010101;
  logic [2:0]  level_i = 3'd0;
  logic [NG-1:0]    tap_sel_o, grp_en_o;
  logic [NG*DW-1:0] push_drv_o, pull_drv_o;
  logic [1:0]  ch_sel_o;
  logic        err_o;

  ldo_loop_ctrl dut (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct packed {
    logic [NG*DW-1:0] push;
    logic [NG*DW-1:0] pull;
    logic [NG-1:0]    tap;
    logic [NG-1:0]    grp;
    logic [1:0]       ch;
    logic             err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  int pm[NG];
  int lm[NG];
  int ptr_m = 0;
  bit err_m = 0;

  function automatic int neff(input logic [1:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic step(input logic e, input logic [1:0] n, input logic [5:0] codes,
                      input logic [2:0] lvl, input string tag);
    exp_t x;
    int nn, lv, eff;
    logic [1:0] c;
    @(negedge clk_i);
    en_i = e; n_ch_i = n; code_i = codes; level_i = lvl;
    nn = neff(n);
    lv = (lvl > 5) ? 5 : int'(lvl);
    c = 2'b01;
    if (e) begin
      eff = ptr_m % nn;
      c = codes[2*eff +: 2];
      ptr_m = (eff + 1 == nn) ? 0 : eff + 1;
      if (c == 2'b10) err_m = 1;
    end else begin
      ptr_m = 0;
    end
    for (int g = 0; g < NG; g++) begin
      if (g > lv) begin
        pm[g] = 0; lm[g] = 0;
      end else if (e && c == 2'b11) begin
        if (pm[g] < 63) pm[g]++;
        if (lm[g] > 0)  lm[g]--;
      end else if (e && c == 2'b00) begin
        if (pm[g] > 0)  pm[g]--;
        if (lm[g] < 63) lm[g]++;
      end
    end
    for (int g = 0; g < NG; g++) begin
      x.push[g*DW +: DW] = DW'(pm[g]);
      x.pull[g*DW +: DW] = DW'(lm[g]);
    end
    x.tap = NG'(1 << lv);
    x.grp = NG'((1 << (lv + 1)) - 1);
    x.ch  = 2'(ptr_m % nn);
    x.err = err_m;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    exp_t x, a;
    string t;
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{push_drv_o, pull_drv_o, tap_sel_o, grp_en_o, ch_sel_o, err_o};
        checks++;
        if (a !== x) begin
          errors++;
          $display("FAIL %s: actual push=%h pull=%h tap=%b grp=%b ch=%0d err=%b expected push=%h pull=%h tap=%b grp=%b ch=%0d err=%b",
                   t, a.push, a.pull, a.tap, a.grp, a.ch, a.err,
                   x.push, x.pull, x.tap, x.grp, x.ch, x.err);
        end
      end
    end
  end

  initial begin : watchdog
    #50000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int g = 0; g < NG; g++) begin pm[g] = 0; lm[g] = 0; end
    repeat (3) @(negedge clk_i);
    // reset state
    checks++;
    if (push_drv_o !== '0 || pull_drv_o !== '0 || err_o !== 1'b0 ||
        tap_sel_o !== 6'b000001 || grp_en_o !== 6'b000001 || ch_sel_o !== 2'd0) begin
      errors++;
      $display("FAIL R7 reset: actual push=%h pull=%h err=%b tap=%b grp=%b expected zero drives, tap/grp 000001",
               push_drv_o, pull_drv_o, err_o, tap_sel_o, grp_en_o);
    end
    rst_ni = 1'b1;

    // R1, R4: raise to the top, push saturates high, pull stays at 0
    for (int i = 0; i < 70; i++) step(1, 2'd1, 6'b010111, 3'd5, "R1 R4 below");
    // R3, R4: lower to the bottom
    for (int i = 0; i < 70; i++) step(1, 2'd1, 6'b010100, 3'd5, "R3 R4 above");
    for (int i = 0; i < 5; i++)  step(1, 2'd1, 6'b010111, 3'd5, "R1 raise");
    // R2: in band holds
    for (int i = 0; i < 4; i++)  step(1, 2'd1, 6'b000001, 3'd5, "R2 band");
    // R5: three channels, distinct codes: ch0 below, ch1 band, ch2 above
    for (int i = 0; i < 9; i++)  step(1, 2'd3, 6'b000111, 3'd5, "R5 rr3");
    // R5: two channels and n=0 acting as one
    for (int i = 0; i < 6; i++)  step(1, 2'd2, 6'b010011, 3'd5, "R5 rr2");
    for (int i = 0; i < 4; i++)  step(1, 2'd0, 6'b000011, 3'd5, "R5 n0");
    // R6: disabled, codes ignored including the bad code
    for (int i = 0; i < 4; i++)  step(0, 2'd3, 6'b101000, 3'd5, "R6 idle");
    for (int i = 0; i < 3; i++)  step(1, 2'd3, 6'b000111, 3'd5, "R6 restart ch0");
    // R10: pointer now at 2; shrink to two channels
    step(1, 2'd3, 6'b000111, 3'd5, "R10 setup");
    step(1, 2'd3, 6'b000111, 3'd5, "R10 setup");
    step(1, 2'd2, 6'b000111, 3'd5, "R10 wrap");
    for (int i = 0; i < 3; i++) step(1, 2'd2, 6'b000111, 3'd5, "R10 continue");
    // R8: drop groups, then re-enable from zero
    for (int i = 0; i < 3; i++) step(1, 2'd1, 6'b000011, 3'd2, "R8 drop");
    for (int i = 0; i < 3; i++) step(1, 2'd1, 6'b000011, 3'd4, "R8 regrow");
    step(1, 2'd1, 6'b000001, 3'd0, "R8 level0");
    // R7: every level and clamping
    for (int l = 0; l < 8; l++) step(1, 2'd1, 6'b000001, 3'(l), "R7 level");
    // R9: bad code holds and flags
    step(1, 2'd1, 6'b000010, 3'd5, "R9 bad");
    for (int i = 0; i < 3; i++) step(1, 2'd1, 6'b000011, 3'd5, "R9 sticky");
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule